// File: doc/BRIEF.md
# UART Control, Status and Interrupt Register Block

This block is the register front end of a UART. Software reaches it through a plain 32-bit register bus with one address, a write strobe, write data and combinational read data. It turns write-one command bits into the receiver and transmitter enable states. It presents a read-only status word built from the levels reported by the serial datapaths. It keeps an interrupt flag word with write-one-to-set and write-one-to-clear aliases and an interrupt enable mask, and from these it drives a single registered interrupt line.

The transmit and receive datapaths sit outside the block. They supply five signals: a transmitter-idle level, two transmit buffer occupancy levels (empty and half full), a receive-data-available level and a receive overrun signal. The transmit-complete, receive-data-valid and receive-overrun flags latch on rising edges of their sources. The transmit buffer flag has no storage and simply tracks the buffer level picked by a control bit.

Top module: `uart_ctl_regs`

## Requirements
- R1: The command word at offset 0x0C has four write-one bits: bit 0 turns the receiver on, bit 1 turns it off, bit 2 turns the transmitter on and bit 3 turns it off. The enable outputs change only on the clock edge of such a write, and reads of 0x0C return zero.
- R2: When one command write carries both the on and the off bit for the same direction, the direction ends up off.
- R3: The status word at offset 0x10 shows the transmitter enable on bit 1, the transmitter-idle level on bit 5, the selected transmit buffer level on bit 6 and the receive-data-available level on bit 7. All other bits read zero.
- R4: Flag bits 0 (transmit complete), 2 (receive data valid) and 4 (receive overrun) are set by a rising edge of tx_idle, rx_valid and rx_overrun respectively, one clock after the source is first seen high. A source that stays high does not set its flag again once the flag has been cleared. A source that is high while reset is released sets nothing.
- R5: Flag bit 1 is the selected transmit buffer level with no delay. Writes to the set and clear aliases leave it unchanged.
- R6: The flag word reads at 0x40 and writes to it are ignored. A write-one at 0x44 sets the latched flags and a write-one at 0x48 clears them. Zero bits leave flags unchanged, and bit 3 always reads zero.
- R7: A hardware rising edge and a software clear of the same flag in the same cycle leave the flag set.
- R8: The enable mask at 0x4C is read/write and keeps only bits 0, 1, 2 and 4. All its other bits read zero.
- R9: irq is a register. It equals the OR of all bits of (flag word AND enable mask) as seen one clock earlier.
- R10: The control word at 0x00 keeps bit 0 (synchronous mode, shown on sync_mode) and bit 12. Bit 12 at 1 makes the transmit buffer flag and status bit follow tx_buf_empty; at 0 they follow tx_buf_half. Other bits read zero.
- R11: After reset both enables, irq, the flag latches, the enable mask and the control word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | ADDR_W | Byte offset for both read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed register (combinational) |
| tx_idle | input | 1 | Transmitter has shifted out everything |
| tx_buf_empty | input | 1 | Transmit buffer is empty |
| tx_buf_half | input | 1 | Transmit buffer is at most half full |
| rx_valid | input | 1 | Receive data is available |
| rx_overrun | input | 1 | Receive buffer overflowed |
| rx_enable | output | 1 | Receiver enable state |
| tx_enable | output | 1 | Transmitter enable state |
| sync_mode | output | 1 | Synchronous mode select from the control word |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong enable state shows at rx_enable or tx_enable and at status bit 1 right after the edge of the command write. A latch that misses or repeats an edge shows in the flag word one clock after the source changes. A set or clear that reaches the level-driven bit shows on the next read of 0x40. An error in the mask or in the interrupt register shows on irq exactly one clock later than the flag change. The bench samples at that cycle, so a one-cycle slip is caught as well as a wrong value.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;

   // register offsets (byte addresses)
   localparam int OFS_CTRL   = 'h00;
   localparam int OFS_CMD    = 'h0C;
   localparam int OFS_STATUS = 'h10;
   localparam int OFS_FLAG   = 'h40;
   localparam int OFS_FSET   = 'h44;
   localparam int OFS_FCLR   = 'h48;
   localparam int OFS_MASK   = 'h4C;

   // command bits: direction d uses bit 2d (on) and bit 2d+1 (off)
   localparam int NUM_DIR = 2;      // 0 = receive, 1 = transmit

   // status bit positions
   localparam int ST_TX_ON  = 1;
   localparam int ST_IDLE   = 5;
   localparam int ST_BUFLVL = 6;
   localparam int ST_RXAV   = 7;

   // flag bit positions
   localparam int FLAG_W     = 5;
   localparam int FL_TXDONE  = 0;
   localparam int FL_BUFLVL  = 1;
   localparam int FL_RXAV    = 2;
   localparam int FL_OVR     = 4;

   // which flag bits latch on edges, which follow a level
   localparam logic [FLAG_W-1:0] LATCH_BITS = 5'b10101;
   localparam logic [FLAG_W-1:0] LEVEL_BITS = 5'b00010;

   // control bit positions
   localparam int CT_SYNC   = 0;
   localparam int CT_BUFSEL = 12;

endpackage

// File: rtl/uart_ctl_latch.sv
// One edge-set interrupt flag with software set and clear.
module uart_ctl_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic sw_set,
   input  logic sw_clr,
   output logic flag
);
   logic prev_q;
   logic rise;

   // prev resets high: a source already high at reset release is not an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;

   // hardware edge dominates a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= rise | sw_set | (flag & ~sw_clr);
   end
endmodule

// File: rtl/uart_ctl_en.sv
// Enable state of one direction, driven by on/off command pulses.
module uart_ctl_en (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic stop,
   output logic en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en <= 1'b0;
      else if (stop) en <= 1'b0;   // off wins when both arrive
      else if (go)   en <= 1'b1;
   end
endmodule

// File: rtl/uart_ctl_regs.sv
module uart_ctl_regs
   import uart_ctl_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tx_idle,
   input  logic              tx_buf_empty,
   input  logic              tx_buf_half,
   input  logic              rx_valid,
   input  logic              rx_overrun,
   output logic              rx_enable,
   output logic              tx_enable,
   output logic              sync_mode,
   output logic              irq
);
   localparam logic [DATA_W-1:0] CTRL_KEEP = DATA_W'((1 << CT_SYNC) | (1 << CT_BUFSEL));
   localparam logic [DATA_W-1:0] MASK_KEEP = DATA_W'(LATCH_BITS | LEVEL_BITS);

   // elaboration-time parameter checks
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (DATA_W < CT_BUFSEL + 1) begin : g_bad_data
      $error("DATA_W too narrow for the control word");
   end

   // write decode
   logic wr_ctrl, wr_cmd, wr_fset, wr_fclr, wr_mask;
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
   assign wr_cmd  = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));
   assign wr_fset = reg_wr && (reg_addr == ADDR_W'(OFS_FSET));
   assign wr_fclr = reg_wr && (reg_addr == ADDR_W'(OFS_FCLR));
   assign wr_mask = reg_wr && (reg_addr == ADDR_W'(OFS_MASK));

   // control and enable-mask storage
   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] ien_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ien_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_KEEP;
         if (wr_mask) ien_q  <= reg_wdata & MASK_KEEP;
      end
   end
   assign sync_mode = ctrl_q[CT_SYNC];

   // selected transmit buffer level
   logic buf_lvl;
   assign buf_lvl = ctrl_q[CT_BUFSEL] ? tx_buf_empty : tx_buf_half;

   // direction enables
   logic [NUM_DIR-1:0] dir_en;
   for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      uart_ctl_en u_en (
         .clk  (clk),
         .rst_n(rst_n),
         .go   (wr_cmd & reg_wdata[2*d]),
         .stop (wr_cmd & reg_wdata[2*d+1]),
         .en   (dir_en[d])
      );
   end
   assign rx_enable = dir_en[0];
   assign tx_enable = dir_en[1];

   // flag sources by bit position; unused positions carry zero
   logic [FLAG_W-1:0] src_vec;
   always_comb begin
      src_vec            = '0;
      src_vec[FL_TXDONE] = tx_idle;
      src_vec[FL_BUFLVL] = buf_lvl;
      src_vec[FL_RXAV]   = rx_valid;
      src_vec[FL_OVR]    = rx_overrun;
   end

   logic [FLAG_W-1:0] if_word;
   for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      if (LATCH_BITS[i]) begin : g_latch
         uart_ctl_latch u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (src_vec[i]),
            .sw_set(wr_fset & reg_wdata[i]),
            .sw_clr(wr_fclr & reg_wdata[i]),
            .flag  (if_word[i])
         );
      end else begin : g_pass
         assign if_word[i] = src_vec[i];
      end
   end

   // registered interrupt
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(if_word & ien_q[FLAG_W-1:0]);
   end

   // status word
   logic [DATA_W-1:0] status_w;
   always_comb begin
      status_w            = '0;
      status_w[ST_TX_ON]  = tx_enable;
      status_w[ST_IDLE]   = tx_idle;
      status_w[ST_BUFLVL] = buf_lvl;
      status_w[ST_RXAV]   = rx_valid;
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_CTRL))        reg_rdata = ctrl_q;
      else if (reg_addr == ADDR_W'(OFS_STATUS)) reg_rdata = status_w;
      else if (reg_addr == ADDR_W'(OFS_FLAG))   reg_rdata = DATA_W'(if_word);
      else if (reg_addr == ADDR_W'(OFS_MASK))   reg_rdata = ien_q;
   end
endmodule

// File: rtl/uart_ctl_chk.sv
module uart_ctl_chk
   import uart_ctl_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              rx_overrun,
   input logic              rx_enable,
   input logic              tx_enable,
   input logic              irq,
   input logic [FLAG_W-1:0] if_word,
   input logic [FLAG_W-1:0] ien_word
);
   logic cmd_wr;
   assign cmd_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));

   AST_RX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && reg_wdata[1]) |=> !rx_enable);  // R2
   AST_TX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && reg_wdata[3]) |=> !tx_enable);  // R2
   AST_EN_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wr |=> $stable({rx_enable, tx_enable}));  // R1
   AST_OVR_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(rx_overrun)) |=> if_word[FL_OVR]);  // R4
   AST_IRQ_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (irq == $past(|(if_word & ien_word))));  // R9

   always_comb begin
      if (rst_n && reg_addr == ADDR_W'(OFS_CMD))
         AST_CMD_READS_ZERO: assert (reg_rdata == '0);  // R1
   end
endmodule

bind uart_ctl_regs uart_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .rx_overrun(rx_overrun),
   .rx_enable (rx_enable),
   .tx_enable (tx_enable),
   .irq       (irq),
   .if_word   (if_word),
   .ien_word  (ien_q[uart_ctl_pkg::FLAG_W-1:0])
);

// File: tb/tb_uart_ctl_regs.sv
module tb_uart_ctl_regs;
   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic tx_idle = 1'b0, tx_buf_empty = 1'b0, tx_buf_half = 1'b0;
   logic rx_valid = 1'b0, rx_overrun = 1'b0;
   logic rx_enable, tx_enable, sync_mode, irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;  // 100 MHz

   uart_ctl_regs #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_idle(tx_idle),
      .tx_buf_empty(tx_buf_empty), .tx_buf_half(tx_buf_half),
      .rx_valid(rx_valid), .rx_overrun(rx_overrun), .rx_enable(rx_enable),
      .tx_enable(tx_enable), .sync_mode(sync_mode), .irq(irq)
   );

   task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input int req);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   // vector: write addr, write data, read addr, expected read, {rx,tx} enables, requirement
   localparam int NV = 16;
   localparam logic [85:0] VEC [NV] = '{
      {8'h0C, 32'h1,        8'h10, 32'h0,  2'b10, 4'd1},  // R1 rx on
      {8'h0C, 32'h4,        8'h10, 32'h2,  2'b11, 4'd1},  // R1 tx on, status bit 1 (R3)
      {8'h0C, 32'h2,        8'h10, 32'h2,  2'b01, 4'd1},  // R1 rx off
      {8'h0C, 32'h5,        8'h10, 32'h2,  2'b11, 4'd1},  // R1 both on
      {8'h0C, 32'h3,        8'h10, 32'h2,  2'b01, 4'd2},  // R2 rx on+off
      {8'h0C, 32'hC,        8'h10, 32'h0,  2'b00, 4'd2},  // R2 tx on+off
      {8'h0C, 32'h5,        8'h0C, 32'h0,  2'b11, 4'd1},  // R1 command reads zero
      {8'h0C, 32'hF,        8'h10, 32'h0,  2'b00, 4'd2},  // R2 all bits
      {8'h4C, 32'hFFFFFFFF, 8'h4C, 32'h17, 2'b00, 4'd8},  // R8 mask keeps 0,1,2,4
      {8'h4C, 32'h0,        8'h4C, 32'h0,  2'b00, 4'd8},  // R8
      {8'h44, 32'h1F,       8'h40, 32'h15, 2'b00, 4'd6},  // R6 set; bit1 level, bit3 zero
      {8'h48, 32'h05,       8'h40, 32'h10, 2'b00, 4'd6},  // R6 partial clear
      {8'h48, 32'h10,       8'h40, 32'h0,  2'b00, 4'd6},  // R6
      {8'h40, 32'h1F,       8'h40, 32'h0,  2'b00, 4'd6},  // R6 flag word not writable
      {8'h00, 32'hFFFFFFFF, 8'h00, 32'h1001, 2'b00, 4'd10}, // R10 control keeps 0 and 12
      {8'h00, 32'h0,        8'h00, 32'h0,  2'b00, 4'd10}  // R10
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(11, {rx_enable, tx_enable, irq, sync_mode}, 4'b0000);
      rd(8'h40, 32'h0, 11);
      rd(8'h4C, 32'h0, 11);
      rd(8'h00, 32'h0, 11);

      for (int k = 0; k < NV; k++) begin
         wr(VEC[k][85:78], VEC[k][77:46]);
         rd(VEC[k][45:38], VEC[k][37:6], int'(VEC[k][3:0]));
         chk(int'(VEC[k][3:0]), {rx_enable, tx_enable}, VEC[k][5:4]);
      end

      // R5 buffer level flag follows tx_buf_half while control bit 12 is 0
      @(negedge clk); tx_buf_half = 1'b1;
      rd(8'h40, 32'h02, 5);
      rd(8'h10, 32'h40, 3);        // R3 status bit 6
      wr(8'h48, 32'h02);
      rd(8'h40, 32'h02, 5);        // clear has no effect
      @(negedge clk); tx_buf_half = 1'b0;
      rd(8'h40, 32'h0, 5);
      wr(8'h44, 32'h02);
      rd(8'h40, 32'h0, 5);         // set has no effect
      // R10 bit 12 selects tx_buf_empty
      wr(8'h00, 32'h1000);
      @(negedge clk); tx_buf_half = 1'b1;
      rd(8'h40, 32'h0, 10);
      tx_buf_empty = 1'b1;
      rd(8'h40, 32'h02, 10);
      rd(8'h10, 32'h40, 10);
      wr(8'h00, 32'h0);
      tx_buf_empty = 1'b0; tx_buf_half = 1'b0;

      // R4 receive data valid latches on a rising edge
      @(negedge clk); rx_valid = 1'b1;
      rd(8'h40, 32'h0, 4);         // not yet: one clock later
      @(negedge clk);
      rd(8'h40, 32'h04, 4);
      rd(8'h10, 32'h80, 3);        // R3 status bit 7
      rx_valid = 1'b0;
      @(negedge clk);
      rd(8'h40, 32'h04, 4);        // held after source drops
      rd(8'h10, 32'h0, 3);
      rx_valid = 1'b1;
      @(negedge clk);
      wr(8'h48, 32'h04);
      repeat (2) @(negedge clk);
      rd(8'h40, 32'h0, 4);         // level still high, no new edge
      rx_valid = 1'b0;
      // R4 transmit complete
      @(negedge clk); tx_idle = 1'b1;
      @(negedge clk);
      rd(8'h40, 32'h01, 4);
      rd(8'h10, 32'h20, 3);        // R3 status bit 5
      wr(8'h48, 32'h01);
      tx_idle = 1'b0;
      rd(8'h40, 32'h0, 6);

      // R7 hardware edge beats software clear in the same cycle
      @(negedge clk);
      rx_overrun = 1'b1; reg_wr = 1'b1; reg_addr = 8'h48; reg_wdata = 32'h10;
      @(negedge clk);
      reg_wr = 1'b0; rx_overrun = 1'b0;
      rd(8'h40, 32'h10, 7);
      wr(8'h48, 32'h10);
      rd(8'h40, 32'h0, 7);

      // R9 registered interrupt
      wr(8'h4C, 32'h04);
      wr(8'h44, 32'h04);
      chk(9, irq, 1'b0);
      @(negedge clk);
      chk(9, irq, 1'b1);
      wr(8'h48, 32'h04);
      chk(9, irq, 1'b1);
      @(negedge clk);
      chk(9, irq, 1'b0);
      wr(8'h44, 32'h10);           // flag set but masked
      repeat (2) @(negedge clk);
      chk(9, irq, 1'b0);
      wr(8'h4C, 32'h10);
      @(negedge clk);
      chk(9, irq, 1'b1);
      wr(8'h4C, 32'h0);
      @(negedge clk);
      chk(9, irq, 1'b0);
      wr(8'h48, 32'h10);

      // R10 synchronous mode output
      wr(8'h00, 32'h1);
      chk(10, sync_mode, 1'b1);
      wr(8'h00, 32'h0);
      chk(10, sync_mode, 1'b0);

      // R11 reset clears state; a source high at release is not an edge (R4)
      wr(8'h0C, 32'h5);
      wr(8'h4C, 32'h17);
      wr(8'h44, 32'h15);
      @(negedge clk);
      rx_overrun = 1'b1;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      rd(8'h40, 32'h0, 11);
      rd(8'h4C, 32'h0, 11);
      chk(11, {rx_enable, tx_enable, irq}, 3'b000);
      rx_overrun = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule